// File: doc/BRIEF.md
# I2S Transmit Serializer

This block is the serial back end of a master-mode I2S playback path. It runs from a master clock, divides it down to a bit clock with a programmable ratio, drives the word-select line, and shifts out the sample words it pulls from an external show-ahead FIFO. Each frame carries two FIFO words, left first, then right. Only the low-order bits of each 32-bit word are sent, as set by a programmable resolution, and they go out MSB first.

Transmission is controlled by a single enable level. Every rising edge of the enable inserts one frame of silence before any queued data is taken. Dropping the enable lets the current frame complete, after which the line goes quiet. When a data slot starts and no word is available, the slot is sent as zeros and an underrun pulse is raised. The FIFO, the register file and the interrupt logic sit outside this block.

Top module: `i2s_tx_serializer`

## Requirements
- R1: The bit clock `sck_o` runs continuously. Each of its half-periods lasts ratio+2 master-clock cycles, so a full period is 2*(ratio+2) cycles, where ratio is the 8-bit `ratio_i`.
- R2: A channel slot lasts `res_i` bit clocks, with `res_i` in 1..32. `ws_o` is 0 for the left slot and 1 for the right slot. Every frame is one left slot followed by one right slot.
- R3: A slot sends bits `res_i`-1 down to 0 of its word, MSB first. Word bits at or above `res_i` have no effect on `sd_o`.
- R4: `ws_o` and `sd_o` change only on the master-clock edge where `sck_o` falls. `ws_o` changes together with the last bit (LSB) of a slot, which is one bit clock before the MSB of the next slot.
- R5: After each rising edge of `tx_en_i`, the block sends one full frame of zeros (left slot, then right slot) before the first data slot. No FIFO read occurs during that frame.
- R6: At the start of each data slot with `fifo_empty_i` low, `fifo_rd_o` pulses for exactly one master-clock cycle. The word on `fifo_data_i` in that cycle is the one sent. Words are consumed in order: left, then right.
- R7: If `fifo_empty_i` is high at the start of a data slot, that slot sends zeros and `underrun_o` pulses for one cycle. Silent-frame slots never raise `underrun_o`.
- R8: When `tx_en_i` goes low, the current frame still completes. After it, `ws_o` and `sd_o` stay low and no reads occur.
- R9: While `rst_ni` is low, `sck_o`, `ws_o`, `sd_o`, `fifo_rd_o` and `underrun_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable level |
| ratio_i | input | 8 | Bit-clock divider setting |
| res_i | input | 6 | Bits sent per slot (1..32) |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_data_i | input | 32 | Head word of the show-ahead FIFO |
| fifo_rd_o | output | 1 | Pop the head word |
| sck_o | output | 1 | I2S bit clock |
| ws_o | output | 1 | I2S word select (0 = left) |
| sd_o | output | 1 | I2S serial data |
| underrun_o | output | 1 | Data slot started with the FIFO empty |

## Verification
The assertions assume a FIFO that never reports data while empty. They also assume that `ratio_i` and `res_i` are held steady while a frame is in flight, with `res_i` inside 1..32. The stimulus changes both settings only when the block is idle. Between changes it waits several bit periods, and it draws resolutions from 8..32. Enable is dropped only after the last right-channel word has been read, so every expected frame sequence is exact.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SILENT = 2'd1,
    ST_DATA   = 2'd2
  } tx_state_e;
endpackage

// File: rtl/i2s_clk_div.sv
module i2s_clk_div #(
  parameter int RATIO_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               sck_o,
  output logic               fall_o
);
  localparam int CNT_W = RATIO_W + 1;

  logic [CNT_W-1:0] cnt_q, limit;
  logic             sck_q, term;

  assign limit  = CNT_W'(ratio_i) + CNT_W'(1);
  assign term   = cnt_q >= limit;  // >= tolerates a ratio drop mid-count
  assign fall_o = term & sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assert_fall_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !sck_o);
endmodule

// File: rtl/i2s_frame_ctrl.sv
module i2s_frame_ctrl
  import i2s_tx_pkg::*;
#(
  parameter int RES_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             tx_en_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             fifo_empty_i,
  output logic             ws_o,
  output logic             fifo_rd_o,
  output logic             underrun_o,
  output logic             sh_load_o,
  output logic             sh_shift_o,
  output logic             sh_clr_o,
  output logic             sh_use_word_o
);
  tx_state_e        state_q;
  logic             chan_q, ws_q, en_q, pend_q;
  logic [RES_W-1:0] pos_q;
  logic             running, slot_start, slot_last, frame_end, en_rise, take_pend, data_st;

  assign running    = state_q != ST_IDLE;
  assign data_st    = state_q == ST_DATA;
  assign slot_start = pos_q == '0;
  assign slot_last  = pos_q == (res_i - RES_W'(1));
  assign frame_end  = running & fall_i & slot_last & chan_q;
  assign en_rise    = tx_en_i & ~en_q;
  assign take_pend  = fall_i & pend_q & (frame_end | ~running);

  assign sh_load_o     = running & fall_i & slot_start;
  assign sh_shift_o    = running & fall_i & ~slot_start;
  assign sh_clr_o      = ~running & fall_i;
  assign fifo_rd_o     = sh_load_o & data_st & ~fifo_empty_i;
  assign underrun_o    = sh_load_o & data_st & fifo_empty_i;
  assign sh_use_word_o = fifo_rd_o;
  assign ws_o          = ws_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      chan_q  <= 1'b0;
      pos_q   <= '0;
      ws_q    <= 1'b0;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      en_q   <= tx_en_i;
      pend_q <= en_rise | (pend_q & ~take_pend);
      if (fall_i) begin
        if (!running) begin
          if (pend_q) begin
            state_q <= ST_SILENT;
            chan_q  <= 1'b0;
            pos_q   <= '0;
            ws_q    <= 1'b0;
          end
        end else if (slot_last) begin
          pos_q  <= '0;
          chan_q <= ~chan_q;
          ws_q   <= ~chan_q;  // next slot's channel, set with this LSB
          if (chan_q) begin
            if (pend_q)       state_q <= ST_SILENT;
            else if (tx_en_i) state_q <= ST_DATA;
            else              state_q <= ST_IDLE;
          end
        end else begin
          pos_q <= pos_q + RES_W'(1);
        end
      end
    end
  end

  assert_ws_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_q) |-> $past(fall_i));
  assert_no_read_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> !fifo_empty_i);
  assert_rd_underrun_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_rd_o && underrun_o));
  assert_silent_no_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SILENT) |-> !fifo_rd_o && !underrun_o);
  assert_idle_ws_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !ws_q && !fifo_rd_o);
endmodule

// File: rtl/i2s_shift.sv
module i2s_shift #(
  parameter int DATA_W = 32,
  parameter int RES_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              clr_i,
  input  logic              use_word_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [RES_W-1:0]  res_i,
  output logic              sd_o
);
  localparam int SH_W = RES_W + 1;

  logic [DATA_W-1:0] sh_q, aligned;
  logic              sd_q;

  // park the low res bits at the top so the MSB leaves first
  assign aligned = use_word_i ? (word_i << (SH_W'(DATA_W) - SH_W'(res_i))) : '0;
  assign sd_o    = sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      sd_q <= 1'b0;
    end else if (load_i) begin
      sd_q <= aligned[DATA_W-1];
      sh_q <= aligned << 1;
    end else if (shift_i) begin
      sd_q <= sh_q[DATA_W-1];
      sh_q <= sh_q << 1;
    end else if (clr_i) begin
      sd_q <= 1'b0;
      sh_q <= '0;
    end
  end

  assert_sd_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_q) |-> $past(load_i || shift_i || clr_i));
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer #(
  parameter int DATA_W  = 32,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [RES_W-1:0]   res_i,
  input  logic               fifo_empty_i,
  input  logic [DATA_W-1:0]  fifo_data_i,
  output logic               fifo_rd_o,
  output logic               sck_o,
  output logic               ws_o,
  output logic               sd_o,
  output logic               underrun_o
);
  logic fall, sh_load, sh_shift, sh_clr, sh_use_word;

  i2s_clk_div #(.RATIO_W(RATIO_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ratio_i(ratio_i),
    .sck_o  (sck_o),
    .fall_o (fall)
  );

  i2s_frame_ctrl #(.RES_W(RES_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fall_i       (fall),
    .tx_en_i      (tx_en_i),
    .res_i        (res_i),
    .fifo_empty_i (fifo_empty_i),
    .ws_o         (ws_o),
    .fifo_rd_o    (fifo_rd_o),
    .underrun_o   (underrun_o),
    .sh_load_o    (sh_load),
    .sh_shift_o   (sh_shift),
    .sh_clr_o     (sh_clr),
    .sh_use_word_o(sh_use_word)
  );

  i2s_shift #(.DATA_W(DATA_W), .RES_W(RES_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sh_load),
    .shift_i   (sh_shift),
    .clr_i     (sh_clr),
    .use_word_i(sh_use_word),
    .word_i    (fifo_data_i),
    .res_i     (res_i),
    .sd_o      (sd_o)
  );
endmodule

// File: tb/tb_i2s_tx_serializer.sv
`timescale 1ns/1ps
module tb_i2s_tx_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic [7:0]  ratio = 8'd0;
  logic [5:0]  res = 6'd32;
  logic        fifo_empty, fifo_rd, sck, ws, sd, underrun;
  logic [31:0] fifo_data;

  always #2 clk = ~clk;

  logic [31:0] fmem [16];
  int wr_p = 0;
  int rd_p = 0;
  assign fifo_empty = (wr_p == rd_p);
  assign fifo_data  = fmem[rd_p % 16];
  always @(posedge clk) if (fifo_rd) rd_p <= rd_p + 1;

  i2s_tx_serializer dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .ratio_i(ratio), .res_i(res),
    .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data), .fifo_rd_o(fifo_rd),
    .sck_o(sck), .ws_o(ws), .sd_o(sd), .underrun_o(underrun)
  );

  int n_chk = 0;
  int n_fail = 0;

  // receiver: samples on sck rise, closes a word on the bit where ws flipped
  logic [63:0] acc = '0;
  int          nb = 0;
  logic        ws_prev = 1'b0;
  logic        sck_prev = 1'b0;
  int          nw = 0;
  int          ur_cnt = 0;
  int          cyc_since = 0;
  int          last_period = 0;
  logic [63:0] dq_val [64];
  logic        dq_ch [64];
  int          dq_nb [64];

  always @(negedge clk) begin
    if (rst_n) begin
      cyc_since = cyc_since + 1;
      if (sck && !sck_prev) begin
        last_period = cyc_since;
        cyc_since = 0;
        acc = {acc[62:0], sd};
        nb = nb + 1;
        if (ws != ws_prev) begin
          if (nw < 64) begin
            dq_val[nw] = acc; dq_ch[nw] = ws_prev; dq_nb[nw] = nb;
            nw = nw + 1;
          end
          acc = '0; nb = 0;
        end
        ws_prev = ws;
      end
      sck_prev = sck;
      if (underrun) ur_cnt = ur_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] res_mask(input int r);
    return (r >= 32) ? 64'hFFFF_FFFF : ((64'd1 << r) - 64'd1);
  endfunction

  task automatic wait_frames(input int k);
    repeat (k * 4 * int'(res) * (int'(ratio) + 2) + 20) @(posedge clk);
  endtask

  task automatic clear_dec();
    @(posedge clk); #1;
    nw = 0; ur_cnt = 0; acc = '0; nb = 0;
  endtask

  task automatic check_words(input int r, input string req);
    for (int i = 0; i < nw; i++) begin
      check(dq_ch[i] == 1'(i % 2), "R2", "slot channel order", longint'(dq_ch[i]), longint'(i % 2));
      if (i > 0) check(dq_nb[i] == r, "R4", "bits between ws flips", dq_nb[i], r);
    end
  endtask

  task automatic run_stream(input int rt, input int rs, input int n);
    logic [31:0] w [8];
    @(posedge clk); #1;
    ratio = 8'(rt); res = 6'(rs);
    wait_frames(2);
    clear_dec();
    for (int i = 0; i < n; i++) begin
      w[i] = $urandom;
      fmem[wr_p % 16] = w[i];
      wr_p = wr_p + 1;
    end
    tx_en = 1'b1;
    for (int k = 0; k < 150000 && rd_p != wr_p; k++) @(posedge clk);
    #1 tx_en = 1'b0;
    wait_frames(3);
    check(nw == n + 2, "R5", "words seen (silence+data)", nw, n + 2);
    check_words(rs, "R2");
    for (int i = 0; i < nw && i < n + 2; i++) begin
      if (i < 2)
        check((dq_val[i] & res_mask(rs)) == 0, "R5", "silent slot", dq_val[i] & res_mask(rs), 0);
      else
        check((dq_val[i] & res_mask(rs)) == (64'(w[i-2]) & res_mask(rs)), "R3",
              "data word low bits", dq_val[i] & res_mask(rs), 64'(w[i-2]) & res_mask(rs));
    end
    check(ur_cnt == 0, "R7", "no underrun with data", ur_cnt, 0);
    #1;
    check(ws == 1'b0 && sd == 1'b0, "R8", "quiet after stop", {ws, sd}, 0);
  endtask

  task automatic run_underrun(input int rt, input int rs);
    @(posedge clk); #1;
    ratio = 8'(rt); res = 6'(rs);
    wait_frames(2);
    clear_dec();
    tx_en = 1'b1;
    wait_frames(4);
    #1 tx_en = 1'b0;
    wait_frames(3);
    check(nw >= 4 && nw % 2 == 0, "R8", "whole frames on underrun stop", nw, 4);
    check(ur_cnt == nw - 2, "R7", "underrun pulse per data slot", ur_cnt, nw - 2);
    for (int i = 0; i < nw; i++)
      check((dq_val[i] & res_mask(rs)) == 0, "R7", "underrun slot zero", dq_val[i] & res_mask(rs), 0);
    check_words(rs, "R2");
  endtask

  task automatic check_period(input int rt);
    @(posedge clk); #1;
    ratio = 8'(rt);
    repeat (8 * (rt + 2) + 10) @(posedge clk);
    @(negedge clk); #0.5;
    check(last_period == 2 * (rt + 2), "R1", "bit clock period", last_period, 2 * (rt + 2));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail = n_fail + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({sck, ws, sd, fifo_rd, underrun} == 5'b0, "R9", "reset outputs",
          {sck, ws, sd, fifo_rd, underrun}, 0);
    #1 rst_n = 1'b1;

    check_period(0);
    check_period(2);
    check_period(7);
    check_period(int'($urandom_range(1, 12)));

    run_stream(0, 32, 4);
    run_stream(2, 16, 2);
    run_stream(1, 8, 6);
    for (int t = 0; t < 3; t++)
      run_stream(int'($urandom_range(0, 4)), int'($urandom_range(8, 32)), 2 * int'($urandom_range(1, 4)));
    run_underrun(0, 12);
    run_underrun(3, 24);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule